// File: doc/BRIEF.md
# Multi-Mode 16-Bit Waveform Timer

This block is a 16-bit counter that produces two waveform outputs, an overflow strobe and two compare-match strobes. A 4-bit mode field selects how it counts and how it drives the waveforms. There are five kinds of operation:

- a free-running up-counter;
- clear-on-compare, with TOP taken from a register;
- single-slope fast PWM;
- dual-slope phase-correct PWM;
- dual-slope phase-and-frequency-correct PWM.

One mode value is reserved. In that mode the timer stands still.

The counter advances only on a cycle where the clock-enable input `tick` is high. Software-style write ports load the following:

- the mode field, split across two control writes;
- compare register A;
- compare register B;
- the capture register, which can serve as TOP.

In some modes the compare registers are double-buffered. A write in those modes reaches the active compare value only at a point set by the mode.

All outputs are registered. Each strobe is high for exactly one cycle. It appears in the cycle after the tick at which its event was seen.

Top module: `pwm_timer16`

## Requirements
- R1: The mode field is built from two writes. Bits 4:3 of the high control write become mode bits 3:2, and bits 1:0 of the low control write become mode bits 1:0; all other bits of those writes are ignored. Reset clears the mode, the counter, both compare registers, the capture register, both waveforms and every strobe to 0.
- R2: The counter, the waveforms and the strobes change only in the cycle after `tick` was high.
- R3: Single-slope modes count up from 0 to TOP and then wrap to 0. These modes and their TOP values are: 0 = 0xFFFF; 4 = compare A; 12 = capture; 5/6/7 = 0x00FF/0x01FF/0x03FF; 14 = capture; 15 = compare A.
- R4: Dual-slope modes count up to TOP and then down to 0, reversing at each end without repeating the end value. These modes and their TOP values are: 1/2/3 = 0x00FF/0x01FF/0x03FF; 8 = capture; 9 = compare A; 10 = capture; 11 = compare A.
- R5: Mode 13 holds the counter, both waveforms and all strobes.
- R6: In modes 0, 4 and 12, a compare write takes effect at once.
- R7: In modes 1–3, 5–7, 10, 11, 14 and 15, a compare write is buffered and copied to the active value on the tick at which the counter holds TOP. In modes 8 and 9 the copy happens on the tick at which the counter holds 0.
- R8: The overflow strobe follows the tick at which the counter holds a mode-specific value. That value is 0xFFFF in modes 0, 4 and 12, TOP in modes 5–7, 14 and 15, and 0 in the dual-slope modes.
- R9: Each match strobe follows the tick at which the counter equals that channel's active compare value.
- R10: In fast PWM modes, a waveform is set on the tick at TOP and cleared on the tick at a compare match. When both happen on the same tick, the set wins.
- R11: In dual-slope modes, a waveform is cleared on a match while counting up and set on a match while counting down.
- R12: In modes 0, 4 and 12, a waveform toggles on each compare match.
- R13: A capture-register write takes effect as TOP at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable |
| ctl_hi_we | input | 1 | High control write strobe |
| ctl_hi_wdata | input | 8 | High control data; bits 4:3 give mode bits 3:2 |
| ctl_lo_we | input | 1 | Low control write strobe |
| ctl_lo_wdata | input | 8 | Low control data; bits 1:0 give mode bits 1:0 |
| cmp_a_we | input | 1 | Compare A write strobe |
| cmp_a_wdata | input | 16 | Compare A data |
| cap_we | input | 1 | Capture register write strobe |
| cap_wdata | input | 16 | Capture register data |
| cmp_b_we | input | 1 | Compare B write strobe |
| cmp_b_wdata | input | 16 | Compare B data |
| count_o | output | 16 | Counter value |
| wave_a_o | output | 1 | Waveform A |
| wave_b_o | output | 1 | Waveform B |
| ovf_o | output | 1 | Overflow strobe |
| match_a_o | output | 1 | Compare A match strobe |
| match_b_o | output | 1 | Compare B match strobe |

## Verification
The assertions on the dual-slope turn assume that TOP is never lowered below the current count while the counter runs. They also assume that TOP is not 0 at the bottom turn.

The stimulus keeps within these limits in three ways:
- it programs each TOP source while the counter is held at 0;
- a mid-run write only ever raises compare A or the capture register;
- in every mode, the values chosen make TOP at least 9 once the first buffer copy has taken place.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    KIND_SINGLE,
    KIND_FAST,
    KIND_DUAL,
    KIND_STOP
  } kind_e;

  typedef enum logic [2:0] {
    TSRC_MAX,
    TSRC_8B,
    TSRC_9B,
    TSRC_10B,
    TSRC_CMPA,
    TSRC_CAP
  } tsrc_e;

  typedef enum logic [1:0] {
    LD_NOW,
    LD_TOP,
    LD_BOT
  } load_e;

  typedef enum logic [1:0] {
    FLAG_MAX,
    FLAG_TOP,
    FLAG_BOT
  } flag_e;

  typedef struct packed {
    kind_e kind;
    tsrc_e tsrc;
    load_e ld;
    flag_e fl;
  } mode_cfg_t;

endpackage

// File: rtl/tmr_mode_decode.sv
module tmr_mode_decode
  import tmr_pkg::*;
(
  input  logic [3:0] mode,
  output mode_cfg_t  cfg
);

  always_comb begin
    cfg = '{kind: KIND_SINGLE, tsrc: TSRC_MAX, ld: LD_NOW, fl: FLAG_MAX};
    case (mode)
      4'd0:  cfg = '{kind: KIND_SINGLE, tsrc: TSRC_MAX,  ld: LD_NOW, fl: FLAG_MAX};
      4'd1:  cfg = '{kind: KIND_DUAL,   tsrc: TSRC_8B,   ld: LD_TOP, fl: FLAG_BOT};
      4'd2:  cfg = '{kind: KIND_DUAL,   tsrc: TSRC_9B,   ld: LD_TOP, fl: FLAG_BOT};
      4'd3:  cfg = '{kind: KIND_DUAL,   tsrc: TSRC_10B,  ld: LD_TOP, fl: FLAG_BOT};
      4'd4:  cfg = '{kind: KIND_SINGLE, tsrc: TSRC_CMPA, ld: LD_NOW, fl: FLAG_MAX};
      4'd5:  cfg = '{kind: KIND_FAST,   tsrc: TSRC_8B,   ld: LD_TOP, fl: FLAG_TOP};
      4'd6:  cfg = '{kind: KIND_FAST,   tsrc: TSRC_9B,   ld: LD_TOP, fl: FLAG_TOP};
      4'd7:  cfg = '{kind: KIND_FAST,   tsrc: TSRC_10B,  ld: LD_TOP, fl: FLAG_TOP};
      4'd8:  cfg = '{kind: KIND_DUAL,   tsrc: TSRC_CAP,  ld: LD_BOT, fl: FLAG_BOT};
      4'd9:  cfg = '{kind: KIND_DUAL,   tsrc: TSRC_CMPA, ld: LD_BOT, fl: FLAG_BOT};
      4'd10: cfg = '{kind: KIND_DUAL,   tsrc: TSRC_CAP,  ld: LD_TOP, fl: FLAG_BOT};
      4'd11: cfg = '{kind: KIND_DUAL,   tsrc: TSRC_CMPA, ld: LD_TOP, fl: FLAG_BOT};
      4'd12: cfg = '{kind: KIND_SINGLE, tsrc: TSRC_CAP,  ld: LD_NOW, fl: FLAG_MAX};
      4'd13: cfg = '{kind: KIND_STOP,   tsrc: TSRC_MAX,  ld: LD_NOW, fl: FLAG_MAX};
      4'd14: cfg = '{kind: KIND_FAST,   tsrc: TSRC_CAP,  ld: LD_TOP, fl: FLAG_TOP};
      default: cfg = '{kind: KIND_FAST, tsrc: TSRC_CMPA, ld: LD_TOP, fl: FLAG_TOP};
    endcase
  end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  kind_e        kind,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         up
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (tick && kind != KIND_STOP) begin
      if (kind == KIND_DUAL) begin
        if (up) begin
          if (cnt >= top) begin
            up  <= 1'b0;
            cnt <= (cnt != '0) ? cnt - ONE : '0;
          end else begin
            cnt <= cnt + ONE;
          end
        end else begin
          if (cnt == '0) begin
            up  <= 1'b1;
            cnt <= (top != '0) ? ONE : '0;
          end else begin
            cnt <= cnt - ONE;
          end
        end
      end else begin
        up  <= 1'b1;
        cnt <= (cnt == top) ? '0 : cnt + ONE;
      end
    end
  end

endmodule

// File: rtl/tmr_cmp_slot.sv
module tmr_cmp_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         imm,
  input  logic         load,
  output logic [W-1:0] act
);

  logic [W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      act    <= '0;
    end else begin
      if (we) shadow <= wdata;
      if (we && imm) act <= wdata;
      else if (load) act <= shadow;
    end
  end

endmodule

// File: rtl/tmr_wave_gen.sv
module tmr_wave_gen
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  kind_e        kind,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top,
  input  logic [W-1:0] cmp,
  input  logic         up,
  output logic         wave
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
    end else if (tick) begin
      case (kind)
        KIND_FAST: begin
          if (cnt == top) wave <= 1'b1;
          else if (cnt == cmp) wave <= 1'b0;
        end
        KIND_DUAL: if (cnt == cmp) wave <= ~up;
        KIND_SINGLE: if (cnt == cmp) wave <= ~wave;
        default: wave <= wave;
      endcase
    end
  end

endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ctl_hi_we,
  input  logic [7:0]   ctl_hi_wdata,
  input  logic         ctl_lo_we,
  input  logic [7:0]   ctl_lo_wdata,
  input  logic         cmp_a_we,
  input  logic [W-1:0] cmp_a_wdata,
  input  logic         cap_we,
  input  logic [W-1:0] cap_wdata,
  input  logic         cmp_b_we,
  input  logic [W-1:0] cmp_b_wdata,
  output logic [W-1:0] count_o,
  output logic         wave_a_o,
  output logic         wave_b_o,
  output logic         ovf_o,
  output logic         match_a_o,
  output logic         match_b_o
);

  localparam int NCH = 2;
  localparam logic [W-1:0] MAXV  = {W{1'b1}};
  localparam logic [W-1:0] TOP8  = W'(255);
  localparam logic [W-1:0] TOP9  = W'(511);
  localparam logic [W-1:0] TOP10 = W'(1023);

  logic [3:0]   mode_q;
  logic [W-1:0] cap_q;
  mode_cfg_t    cfg;
  logic [W-1:0] cnt;
  logic         cnt_up;
  logic [W-1:0] top_val;
  logic         live, at_top, at_bot, at_max, load;

  logic         we_ch   [NCH];
  logic [W-1:0] wd_ch   [NCH];
  logic [W-1:0] act_ch  [NCH];
  logic         wave_ch [NCH];
  logic         hit_ch  [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      cap_q  <= '0;
    end else begin
      if (ctl_hi_we) mode_q[3:2] <= ctl_hi_wdata[4:3];
      if (ctl_lo_we) mode_q[1:0] <= ctl_lo_wdata[1:0];
      if (cap_we)    cap_q       <= cap_wdata;
    end
  end

  tmr_mode_decode u_dec (.mode(mode_q), .cfg(cfg));

  always_comb begin
    case (cfg.tsrc)
      TSRC_8B:   top_val = TOP8;
      TSRC_9B:   top_val = TOP9;
      TSRC_10B:  top_val = TOP10;
      TSRC_CMPA: top_val = act_ch[0];
      TSRC_CAP:  top_val = cap_q;
      default:   top_val = MAXV;
    endcase
  end

  assign live   = tick && (cfg.kind != KIND_STOP);
  assign at_top = live && (cnt == top_val);
  assign at_bot = live && (cnt == '0);
  assign at_max = live && (cnt == MAXV);

  always_comb begin
    case (cfg.ld)
      LD_TOP:  load = at_top;
      LD_BOT:  load = at_bot;
      default: load = 1'b0;
    endcase
  end

  tmr_count_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .kind(cfg.kind),
    .top(top_val), .cnt(cnt), .up(cnt_up)
  );

  assign we_ch[0] = cmp_a_we;
  assign we_ch[1] = cmp_b_we;
  assign wd_ch[0] = cmp_a_wdata;
  assign wd_ch[1] = cmp_b_wdata;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_cmp_slot #(.W(W)) u_slot (
      .clk(clk), .rst(rst), .we(we_ch[c]), .wdata(wd_ch[c]),
      .imm(cfg.ld == LD_NOW), .load(load), .act(act_ch[c])
    );

    tmr_wave_gen #(.W(W)) u_wave (
      .clk(clk), .rst(rst), .tick(live), .kind(cfg.kind), .cnt(cnt),
      .top(top_val), .cmp(act_ch[c]), .up(cnt_up), .wave(wave_ch[c])
    );

    always_ff @(posedge clk) begin
      if (rst) hit_ch[c] <= 1'b0;
      else     hit_ch[c] <= live && (cnt == act_ch[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_o <= 1'b0;
    end else begin
      case (cfg.fl)
        FLAG_TOP: ovf_o <= at_top;
        FLAG_BOT: ovf_o <= at_bot;
        default:  ovf_o <= at_max;
      endcase
    end
  end

  assign count_o   = cnt;
  assign wave_a_o  = wave_ch[0];
  assign wave_b_o  = wave_ch[1];
  assign match_a_o = hit_ch[0];
  assign match_b_o = hit_ch[1];

endmodule

// File: rtl/pwm_timer16_chk.sv
module pwm_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [3:0]   mode,
  input logic [W-1:0] count,
  input logic [W-1:0] top,
  input logic         up,
  input logic         ovf
);

  logic single_m, dual_m;
  assign single_m = mode inside {4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd14, 4'd15};
  assign dual_m   = mode inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11};

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  assert_reserved_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd13) |=> $stable(count));

  assert_single_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && single_m && count == top) |=> (count == '0));

  assert_dual_rebound_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && dual_m && !up && count == '0 && top != '0) |=> (count == W'(1) && up));

  assert_ovf_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |-> $past(tick));

endmodule

bind pwm_timer16 pwm_timer16_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .mode(mode_q), .count(cnt),
  .top(top_val), .up(cnt_up), .ovf(ovf_o)
);

// File: tb/pwm_timer16_bench.sv
module pwm_timer16_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        ctl_hi_we = 1'b0, ctl_lo_we = 1'b0;
  logic [7:0]  ctl_hi_wdata = '0, ctl_lo_wdata = '0;
  logic        cmp_a_we = 1'b0, cap_we = 1'b0, cmp_b_we = 1'b0;
  logic [15:0] cmp_a_wdata = '0, cap_wdata = '0, cmp_b_wdata = '0;
  logic [15:0] count_o;
  logic        wave_a_o, wave_b_o, ovf_o, match_a_o, match_b_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_timer16 u_pwm_timer16 (
    .clk(clk), .rst(rst), .tick(tick),
    .ctl_hi_we(ctl_hi_we), .ctl_hi_wdata(ctl_hi_wdata),
    .ctl_lo_we(ctl_lo_we), .ctl_lo_wdata(ctl_lo_wdata),
    .cmp_a_we(cmp_a_we), .cmp_a_wdata(cmp_a_wdata),
    .cap_we(cap_we), .cap_wdata(cap_wdata),
    .cmp_b_we(cmp_b_we), .cmp_b_wdata(cmp_b_wdata),
    .count_o(count_o), .wave_a_o(wave_a_o), .wave_b_o(wave_b_o),
    .ovf_o(ovf_o), .match_a_o(match_a_o), .match_b_o(match_b_o)
  );

  // reference model, built from the requirements
  logic [3:0]  m_mode;
  logic [15:0] m_cnt, m_icr;
  logic        m_up;
  logic [15:0] m_act [2];
  logic [15:0] m_buf [2];
  logic        m_wave [2];
  logic        m_hit [2];
  logic        m_ovf;

  function automatic bit is_dual(input logic [3:0] m);
    return m inside {1, 2, 3, 8, 9, 10, 11};
  endfunction
  function automatic bit is_fast(input logic [3:0] m);
    return m inside {5, 6, 7, 14, 15};
  endfunction
  function automatic bit is_imm(input logic [3:0] m);
    return m inside {0, 4, 12};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_icr = 0; m_up = 1; m_ovf = 0;
      for (int i = 0; i < 2; i++) begin
        m_act[i] = 0; m_buf[i] = 0; m_wave[i] = 0; m_hit[i] = 0;
      end
    end else begin
      logic [15:0] tp;
      logic ev, htop, hbot, hmax, upd;
      logic [15:0] wd [2];
      logic we [2];
      case (m_mode)
        1, 5: tp = 16'd255;
        2, 6: tp = 16'd511;
        3, 7: tp = 16'd1023;
        4, 9, 11, 15: tp = m_act[0];
        8, 10, 12, 14: tp = m_icr;
        default: tp = 16'hFFFF;
      endcase
      ev   = tick && (m_mode != 13);
      htop = ev && (m_cnt == tp);
      hbot = ev && (m_cnt == 0);
      hmax = ev && (m_cnt == 16'hFFFF);
      m_ovf = is_imm(m_mode) ? hmax : (is_fast(m_mode) ? htop : hbot);
      upd = is_imm(m_mode) ? 1'b0 : ((m_mode inside {8, 9}) ? hbot : htop);
      for (int i = 0; i < 2; i++) begin
        m_hit[i] = ev && (m_cnt == m_act[i]);
        if (ev) begin
          if (is_fast(m_mode)) begin
            if (htop) m_wave[i] = 1;
            else if (m_hit[i]) m_wave[i] = 0;
          end else if (is_dual(m_mode)) begin
            if (m_hit[i]) m_wave[i] = !m_up;
          end else if (m_hit[i]) m_wave[i] = !m_wave[i];
        end
      end
      if (ev) begin
        if (is_dual(m_mode)) begin
          if (m_up) begin
            if (m_cnt >= tp) begin m_up = 0; m_cnt = (m_cnt != 0) ? m_cnt - 1 : 0; end
            else m_cnt = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin m_up = 1; m_cnt = (tp != 0) ? 16'd1 : 16'd0; end
            else m_cnt = m_cnt - 1;
          end
        end else begin
          m_up = 1;
          m_cnt = (m_cnt == tp) ? 16'd0 : m_cnt + 16'd1;
        end
      end
      we[0] = cmp_a_we; wd[0] = cmp_a_wdata;
      we[1] = cmp_b_we; wd[1] = cmp_b_wdata;
      for (int i = 0; i < 2; i++) begin
        if (upd) m_act[i] = m_buf[i];
        if (we[i]) begin
          m_buf[i] = wd[i];
          if (is_imm(m_mode)) m_act[i] = wd[i];
        end
      end
      if (cap_we) m_icr = cap_wdata;
      if (ctl_hi_we) m_mode[3:2] = ctl_hi_wdata[4:3];
      if (ctl_lo_we) m_mode[1:0] = ctl_lo_wdata[1:0];
    end
  end

  task automatic chk1(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    if (act !== exp) begin
      n_bad++;
      if (n_bad < 30) $display("FAIL %s %s mode=%0d actual=%0h expected=%0h", req, what, m_mode, act, exp);
    end
  endtask

  task automatic step_check();
    string wreq;
    @(negedge clk);
    n_vec++;
    wreq = is_fast(m_mode) ? "R10" : (is_dual(m_mode) ? "R11" : "R12");
    chk1(is_dual(m_mode) ? "R4 R13" : "R3 R13", "count", count_o, m_cnt);
    chk1(wreq, "wave_a", {15'd0, wave_a_o}, {15'd0, m_wave[0]});
    chk1(wreq, "wave_b", {15'd0, wave_b_o}, {15'd0, m_wave[1]});
    chk1("R8", "ovf", {15'd0, ovf_o}, {15'd0, m_ovf});
    chk1("R9 R6 R7", "match_a", {15'd0, match_a_o}, {15'd0, m_hit[0]});
    chk1("R9 R6 R7", "match_b", {15'd0, match_b_o}, {15'd0, m_hit[1]});
  endtask

  task automatic run_mode(input int m);
    logic [15:0] a, b, c;
    int len;
    rst = 1'b1; tick = 1'b0;
    step_check(); step_check();
    rst = 1'b0;
    step_check();
    // R1: reset state at the ports
    n_vec++;
    if (count_o !== 0 || wave_a_o !== 0 || wave_b_o !== 0 || ovf_o !== 0 || match_a_o !== 0 || match_b_o !== 0) begin
      n_bad++;
      $display("FAIL R1 reset state actual=%0h/%b%b%b%b%b expected=0/00000",
               count_o, wave_a_o, wave_b_o, ovf_o, match_a_o, match_b_o);
    end
    // R1: mode field with junk in the ignored bits
    ctl_hi_we = 1; ctl_hi_wdata = {3'b101, 2'(m >> 2), 3'b011};
    ctl_lo_we = 1; ctl_lo_wdata = {6'b101010, 2'(m)};
    step_check();
    ctl_hi_we = 0; ctl_lo_we = 0;
    if (m inside {4, 9, 11, 15}) begin a = 9; b = 4; end
    else if (m == 12) begin a = 5; b = 8; end
    else begin a = 100; b = 40; end
    c = 11;
    cmp_a_we = 1; cmp_a_wdata = a; cmp_b_we = 1; cmp_b_wdata = b; cap_we = 1; cap_wdata = c;
    step_check();
    cmp_a_we = 0; cmp_b_we = 0; cap_we = 0;
    step_check();
    // R2: no tick yet, counter still at 0
    n_vec++;
    if (count_o !== 0) begin
      n_bad++;
      $display("FAIL R2 count moved without tick actual=%0h expected=0", count_o);
    end
    len = (m == 0) ? 66000 : 3000;
    for (int k = 0; k < len; k++) begin
      tick = (m == 0) ? 1'b1 : ((k % 4) != 3);
      if (k == 500 || k == 1700) begin
        a = a + 2; b = b + 3; c = c + 1;
        cmp_a_we = 1; cmp_a_wdata = a; cmp_b_we = 1; cmp_b_wdata = b; cap_we = 1; cap_wdata = c;
      end
      step_check();
      cmp_a_we = 0; cmp_b_we = 0; cap_we = 0;
    end
    tick = 0;
    if (m == 13) begin
      // R5: reserved mode leaves everything at rest
      n_vec++;
      if (count_o !== 0 || wave_a_o !== 0 || wave_b_o !== 0) begin
        n_bad++;
        $display("FAIL R5 reserved mode moved actual=%0h/%b%b expected=0/00", count_o, wave_a_o, wave_b_o);
      end
    end
  endtask

  initial begin
    for (int m = 0; m < 16; m++) run_mode(m);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule